// File: doc/BRIEF.md
# Partitioned Fully Associative Translation Buffer

This block holds a small set of address translations and answers lookups in a single cycle. Each stored translation carries a virtual address, a physical address, a partition number, a context number, a flag marking it as a real (untranslated-mode) mapping, a 2-bit page-size code and a lock bit. All entries are compared in parallel against every request. A hit returns the lowest matching entry index and a physical address. That address takes its page bits from the entry and its in-page offset bits from the request.

One command port carries six operations: lookup, insert, demap by page, demap by context, demap by partition and invalidate-all. A command is accepted in the cycle where `cmd_valid` and `cmd_ready` are both high, and its effect is visible to the next command. Inserts fill the lowest free slot first. When the buffer is full, inserts replace an unlocked entry chosen by a rotating pointer. Locked entries are protected from replacement and from partition sweeps, but not from page demaps, context demaps or invalidate-all.

Top module: `pfa_tlb`

## Requirements
- R1: `cmd_op` encodes lookup=0, insert=1, demap-page=2, demap-context=3, demap-partition=4, invalidate-all=5. `cmd_ready` is high from the first clock edge after reset is released. A command takes effect only in a cycle where `cmd_valid` and `cmd_ready` are both high.
- R2: An accepted lookup raises `rsp_valid` for exactly the next cycle, with exactly one of `rsp_hit` and `rsp_miss` set. On a miss, `rsp_idx` and `rsp_pa` are 0. Other operations give no response.
- R3: A lookup hits an entry only when all of these hold: the entry is valid; partition and real flag are equal; the contexts are equal; and the virtual bits above the entry's page offset are equal. For a real lookup, the compared context is 0, and a real insert stores context 0. If several entries match, the lowest index is reported.
- R4: Page-size code 0, 1, 2 and 3 give 13, 16, 22 and 28 offset bits. `rsp_pa` is the entry's physical address with those low bits cleared, ORed with the same low bits of the lookup address.
- R5: While any entry is invalid, an insert writes the lowest-indexed invalid entry.
- R6: When all entries are valid, an insert writes the first unlocked entry at or after a rotating pointer, wrapping around, and moves the pointer to the slot after it. If every entry is locked, the insert is dropped.
- R7: Demap-page invalidates every entry that a lookup with the same address, partition, context and real flag would match, whether or not it is locked.
- R8: Demap-context invalidates every valid entry whose partition and context equal the command's, regardless of lock and real flag. Other entries keep their state.
- R9: Demap-partition invalidates the unlocked entries of the given partition. Locked entries of that partition and entries of other partitions survive.
- R10: Invalidate-all clears every entry regardless of lock, partition or context.
- R11: Opcodes 6 and 7 change no entry and produce no response.
- R12: After reset, no entry is valid, no response is pending and the rotating pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Operation code |
| cmd_va | input | VA_W | Virtual address (lookup, insert, demap-page) |
| cmd_pa | input | PA_W | Physical address for insert |
| cmd_part | input | PART_W | Partition number |
| cmd_ctx | input | CTX_W | Context number |
| cmd_real | input | 1 | Real (untranslated-mode) flag |
| cmd_psize | input | 2 | Page-size code for insert |
| cmd_lock | input | 1 | Lock bit for insert |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_miss | output | 1 | Lookup found no entry |
| rsp_idx | output | IDX_W | Index of the hit entry |
| rsp_pa | output | PA_W | Translated physical address |

## Verification
Some properties are checked on every cycle. One is that each accepted lookup gets its response in the next cycle. Another is that sweeps clear exactly the slots they should: partition sweeps leave locked entries alive, context sweeps ignore the lock, and invalidate-all empties the array. The victim selector is also checked on every cycle: it prefers a free slot and never picks a locked one once the array is full. Other behaviour can only be shown by the bench's scenarios, run against a behavioural model. This covers the merged physical address for each page size, the rotation order of replacements, dropped inserts into a fully locked array, and the lowest-index choice among duplicate entries.

// File: rtl/pfa_tlb_pkg.sv
package pfa_tlb_pkg;

   typedef enum logic [2:0] {
      OP_LOOKUP     = 3'd0,
      OP_INSERT     = 3'd1,
      OP_DEMAP_PAGE = 3'd2,
      OP_DEMAP_CTX  = 3'd3,
      OP_DEMAP_PART = 3'd4,
      OP_INVAL_ALL  = 3'd5
   } tlb_op_e;

   localparam int unsigned MAX_OFFSET_BITS = 28;

   // number of in-page offset bits for a 2-bit size code
   function automatic int unsigned offset_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 13;
         2'd1:    return 16;
         2'd2:    return 22;
         default: return 28;
      endcase
   endfunction

   function automatic logic [63:0] offset_mask(input logic [1:0] code);
      return (64'd1 << offset_bits(code)) - 64'd1;
   endfunction

endpackage

// File: rtl/pfa_tlb_match.sv
module pfa_tlb_match #(
   parameter int N      = 16,
   parameter int VA_W   = 40,
   parameter int PART_W = 8,
   parameter int CTX_W  = 13
) (
   input  logic [N-1:0]             ent_valid,
   input  logic [N-1:0]             ent_lock,
   input  logic [N-1:0]             ent_real,
   input  logic [N-1:0][PART_W-1:0] ent_part,
   input  logic [N-1:0][CTX_W-1:0]  ent_ctx,
   input  logic [N-1:0][VA_W-1:0]   ent_va,
   input  logic [N-1:0][1:0]        ent_psz,
   input  logic [VA_W-1:0]          q_va,
   input  logic [PART_W-1:0]        q_part,
   input  logic [CTX_W-1:0]         q_ctx,
   input  logic                     q_real,
   output logic [N-1:0]             tuple_hit,
   output logic [N-1:0]             ctx_hit,
   output logic [N-1:0]             part_hit,
   output logic                     any_hit,
   output logic [$clog2(N)-1:0]     first_idx
);
   import pfa_tlb_pkg::*;

   localparam int IDX_W = $clog2(N);

   logic [CTX_W-1:0] q_ctx_eff;
   assign q_ctx_eff = q_real ? '0 : q_ctx;

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [VA_W-1:0] off_m;
      logic            page_eq;
      logic            part_eq;
      assign off_m    = VA_W'(offset_mask(ent_psz[i]));
      assign page_eq  = ((ent_va[i] ^ q_va) & ~off_m) == '0;
      assign part_eq  = ent_part[i] == q_part;
      assign tuple_hit[i] = ent_valid[i] & part_eq & (ent_real[i] == q_real) &
                            (ent_ctx[i] == q_ctx_eff) & page_eq;
      assign ctx_hit[i]   = ent_valid[i] & part_eq & (ent_ctx[i] == q_ctx);
      assign part_hit[i]  = ent_valid[i] & part_eq & ~ent_lock[i];
   end

   assign any_hit = |tuple_hit;

   always_comb begin
      first_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (tuple_hit[i]) first_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pfa_tlb_victim.sv
module pfa_tlb_victim #(
   parameter int N = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         valid,
   input  logic [N-1:0]         lock,
   input  logic [$clog2(N)-1:0] rr_ptr,
   output logic [$clog2(N)-1:0] victim_idx,
   output logic                 victim_ok,
   output logic                 from_rr
);
   localparam int IDX_W = $clog2(N);

   logic             have_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_idx;
   logic             rr_ok;

   function automatic logic [IDX_W-1:0] rot(input logic [IDX_W-1:0] base,
                                            input int unsigned k);
      logic [IDX_W:0] s;
      s = {1'b0, base} + (IDX_W+1)'(k);
      if (s >= (IDX_W+1)'(N)) s = s - (IDX_W+1)'(N);
      return s[IDX_W-1:0];
   endfunction

   assign have_free = |(~valid);

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      rr_idx = '0;
      rr_ok  = 1'b0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!lock[rot(rr_ptr, k)]) begin
            rr_idx = rot(rr_ptr, k);
            rr_ok  = 1'b1;
         end
      end
   end

   assign victim_idx = have_free ? free_idx : rr_idx;
   assign victim_ok  = have_free | rr_ok;
   assign from_rr    = ~have_free & rr_ok;

   // R5
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      have_free |-> (victim_ok && !valid[victim_idx]));

   // R6
   no_locked_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_ok && !have_free) |-> !lock[victim_idx]);

endmodule

// File: rtl/pfa_tlb.sv
module pfa_tlb #(
   parameter int N      = 16,
   parameter int VA_W   = 40,
   parameter int PA_W   = 40,
   parameter int PART_W = 8,
   parameter int CTX_W  = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [2:0]           cmd_op,
   input  logic [VA_W-1:0]      cmd_va,
   input  logic [PA_W-1:0]      cmd_pa,
   input  logic [PART_W-1:0]    cmd_part,
   input  logic [CTX_W-1:0]     cmd_ctx,
   input  logic                 cmd_real,
   input  logic [1:0]           cmd_psize,
   input  logic                 cmd_lock,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_miss,
   output logic [$clog2(N)-1:0] rsp_idx,
   output logic [PA_W-1:0]      rsp_pa
);
   import pfa_tlb_pkg::*;

   localparam int IDX_W = $clog2(N);

   if (N < 2 || N > 64) begin : g_bad_depth
      $error("pfa_tlb: N must lie in 2..64");
   end
   if (VA_W <= int'(MAX_OFFSET_BITS) || VA_W > 64) begin : g_bad_va
      $error("pfa_tlb: VA_W must lie in 29..64");
   end
   if (PA_W <= int'(MAX_OFFSET_BITS) || PA_W > 64) begin : g_bad_pa
      $error("pfa_tlb: PA_W must lie in 29..64");
   end

   // entry storage
   logic [N-1:0]             ent_valid;
   logic [N-1:0]             ent_lock;
   logic [N-1:0]             ent_real;
   logic [N-1:0][PART_W-1:0] ent_part;
   logic [N-1:0][CTX_W-1:0]  ent_ctx;
   logic [N-1:0][VA_W-1:0]   ent_va;
   logic [N-1:0][PA_W-1:0]   ent_pa;
   logic [N-1:0][1:0]        ent_psz;
   logic [IDX_W-1:0]         rr_ptr;
   logic                     ready_q;

   tlb_op_e op;
   logic    go;
   assign op        = tlb_op_e'(cmd_op);
   assign cmd_ready = ready_q;
   assign go        = cmd_valid & ready_q;

   // associative compare
   logic [N-1:0]     tuple_hit, ctx_hit, part_hit;
   logic             any_hit;
   logic [IDX_W-1:0] hit_idx;

   pfa_tlb_match #(.N(N), .VA_W(VA_W), .PART_W(PART_W), .CTX_W(CTX_W)) i_match (
      .ent_valid (ent_valid),
      .ent_lock  (ent_lock),
      .ent_real  (ent_real),
      .ent_part  (ent_part),
      .ent_ctx   (ent_ctx),
      .ent_va    (ent_va),
      .ent_psz   (ent_psz),
      .q_va      (cmd_va),
      .q_part    (cmd_part),
      .q_ctx     (cmd_ctx),
      .q_real    (cmd_real),
      .tuple_hit (tuple_hit),
      .ctx_hit   (ctx_hit),
      .part_hit  (part_hit),
      .any_hit   (any_hit),
      .first_idx (hit_idx)
   );

   // replacement choice
   logic [IDX_W-1:0] vic_idx;
   logic             vic_ok;
   logic             vic_rr;

   pfa_tlb_victim #(.N(N)) i_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (ent_valid),
      .lock       (ent_lock),
      .rr_ptr     (rr_ptr),
      .victim_idx (vic_idx),
      .victim_ok  (vic_ok),
      .from_rr    (vic_rr)
   );

   logic do_insert;
   assign do_insert = go && (op == OP_INSERT) && vic_ok;

   // next valid vector
   logic [N-1:0] valid_d;
   always_comb begin
      valid_d = ent_valid;
      if (go) begin
         case (op)
            OP_INSERT:     if (vic_ok) valid_d[vic_idx] = 1'b1;
            OP_DEMAP_PAGE: valid_d = ent_valid & ~tuple_hit;
            OP_DEMAP_CTX:  valid_d = ent_valid & ~ctx_hit;
            OP_DEMAP_PART: valid_d = ent_valid & ~part_hit;
            OP_INVAL_ALL:  valid_d = '0;
            default:       valid_d = ent_valid;
         endcase
      end
   end

   logic [IDX_W-1:0] rr_next;
   assign rr_next = (vic_idx == IDX_W'(N - 1)) ? '0 : vic_idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         ent_valid <= '0;
         ent_lock  <= '0;
         ent_real  <= '0;
         ent_part  <= '0;
         ent_ctx   <= '0;
         ent_va    <= '0;
         ent_pa    <= '0;
         ent_psz   <= '0;
         rr_ptr    <= '0;
      end else begin
         ready_q   <= 1'b1;
         ent_valid <= valid_d;
         if (do_insert) begin
            ent_lock[vic_idx] <= cmd_lock;
            ent_real[vic_idx] <= cmd_real;
            ent_part[vic_idx] <= cmd_part;
            ent_ctx[vic_idx]  <= cmd_real ? '0 : cmd_ctx;
            ent_va[vic_idx]   <= cmd_va;
            ent_pa[vic_idx]   <= cmd_pa;
            ent_psz[vic_idx]  <= cmd_psize;
            if (vic_rr) rr_ptr <= rr_next;
         end
      end
   end

   // physical address merge
   logic [PA_W-1:0] pa_mask;
   logic [PA_W-1:0] pa_merged;
   assign pa_mask   = PA_W'(offset_mask(ent_psz[hit_idx]));
   assign pa_merged = (ent_pa[hit_idx] & ~pa_mask) | (PA_W'(cmd_va) & pa_mask);

   logic             rsp_valid_q, rsp_hit_q;
   logic [IDX_W-1:0] rsp_idx_q;
   logic [PA_W-1:0]  rsp_pa_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_idx_q   <= '0;
         rsp_pa_q    <= '0;
      end else begin
         rsp_valid_q <= go && (op == OP_LOOKUP);
         rsp_hit_q   <= go && (op == OP_LOOKUP) && any_hit;
         rsp_idx_q   <= any_hit ? hit_idx : '0;
         rsp_pa_q    <= any_hit ? pa_merged : '0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_hit   = rsp_hit_q;
   assign rsp_miss  = rsp_valid_q & ~rsp_hit_q;
   assign rsp_idx   = rsp_idx_q;
   assign rsp_pa    = rsp_pa_q;

   // R2
   lookup_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OP_LOOKUP) |=> (rsp_valid && (rsp_hit != rsp_miss)));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_idx == '0 && rsp_pa == '0));

   // R11
   no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && op == OP_LOOKUP) |=> !rsp_valid);

   // R10
   inval_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OP_INVAL_ALL) |=> (ent_valid == '0));

   for (genvar i = 0; i < N; i++) begin : g_sweep_chk
      // R9
      part_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (go && op == OP_DEMAP_PART && ent_part[i] == cmd_part && !ent_lock[i])
            |=> !ent_valid[i]);
      // R9
      lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (go && op == OP_DEMAP_PART && ent_valid[i] && ent_lock[i]) |=> ent_valid[i]);
      // R8
      ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (go && op == OP_DEMAP_CTX && ent_part[i] == cmd_part && ent_ctx[i] == cmd_ctx)
            |=> !ent_valid[i]);
   end

endmodule

// File: tb/test_pfa_tlb.sv
module test_pfa_tlb;
   localparam int N      = 16;
   localparam int VA_W   = 40;
   localparam int PA_W   = 40;
   localparam int PART_W = 8;
   localparam int CTX_W  = 13;
   localparam int IDX_W  = $clog2(N);
   localparam logic [63:0] VA_M = (64'd1 << VA_W) - 1;
   localparam logic [63:0] PA_M = (64'd1 << PA_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [2:0] cmd_op = '0;
   logic [VA_W-1:0] cmd_va = '0;
   logic [PA_W-1:0] cmd_pa = '0;
   logic [PART_W-1:0] cmd_part = '0;
   logic [CTX_W-1:0] cmd_ctx = '0;
   logic cmd_real = 1'b0;
   logic [1:0] cmd_psize = '0;
   logic cmd_lock = 1'b0;
   logic rsp_valid, rsp_hit, rsp_miss;
   logic [IDX_W-1:0] rsp_idx;
   logic [PA_W-1:0] rsp_pa;

   always #2 clk = ~clk;

   pfa_tlb #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .PART_W(PART_W), .CTX_W(CTX_W)) i_pfa_tlb (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_pa(cmd_pa), .cmd_part(cmd_part),
      .cmd_ctx(cmd_ctx), .cmd_real(cmd_real), .cmd_psize(cmd_psize), .cmd_lock(cmd_lock),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_idx(rsp_idx), .rsp_pa(rsp_pa)
   );

   int checks = 0;
   int failures = 0;

   // behavioural model
   bit          mv[N];
   bit          ml[N];
   bit          mr[N];
   int          mpart[N];
   int          mctx[N];
   int          mps[N];
   logic [63:0] mva[N];
   logic [63:0] mpa[N];
   int          mrr = 0;

   bit          ev = 0;
   bit          eh = 0;
   int          ei = 0;
   logic [63:0] epa = '0;
   string       etag = "R12";

   function automatic logic [63:0] omask(input int c);
      int s;
      s = (c == 0) ? 13 : (c == 1) ? 16 : (c == 2) ? 22 : 28;
      return (64'd1 << s) - 1;
   endfunction

   function automatic bit mhit(input int i, input logic [63:0] va, input int part,
                               input int ctx, input bit rl);
      return mv[i] && mpart[i] == part && mr[i] == rl && mctx[i] == (rl ? 0 : ctx) &&
             (((mva[i] ^ va) & ~omask(mps[i])) == 0);
   endfunction

   task automatic check_rsp();
      bit bad;
      logic [63:0] xi, xp;
      checks++;
      xi = (ev && eh) ? 64'(ei) : 64'd0;
      xp = (ev && eh) ? epa : 64'd0;
      bad = (rsp_valid !== ev) || (rsp_miss !== (ev && !eh));
      if (ev) bad = bad || (rsp_hit !== eh) || (64'(rsp_idx) !== xi) || (64'(rsp_pa) !== xp);
      else    bad = bad || (rsp_hit !== 1'b0);
      if (bad) begin
         failures++;
         $display("FAIL %s: rsp v/h/m/idx/pa actual %0d/%0d/%0d/%0d/%h expected %0d/%0d/%0d/%0d/%h",
                  etag, rsp_valid, rsp_hit, rsp_miss, rsp_idx, rsp_pa,
                  ev, eh, ev && !eh, xi, xp);
      end
   endtask

   task automatic model(input bit vld, input int op, input logic [63:0] va,
                        input logic [63:0] pa, input int part, input int ctx,
                        input bit rl, input int ps, input bit lk);
      ev = 0;
      eh = 0;
      if (!vld) return;
      case (op)
         0: begin
            int f;
            f = -1;
            for (int i = N - 1; i >= 0; i--) if (mhit(i, va, part, ctx, rl)) f = i;
            ev = 1;
            eh = (f >= 0);
            ei = eh ? f : 0;
            epa = eh ? (((mpa[f] & ~omask(mps[f])) | (va & omask(mps[f]))) & PA_M) : 0;
         end
         1: begin
            int v;
            v = -1;
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) v = i;
            if (v < 0) begin
               for (int k = N - 1; k >= 0; k--) if (!ml[(mrr + k) % N]) v = (mrr + k) % N;
               if (v >= 0) mrr = (v + 1) % N;
            end
            if (v >= 0) begin
               mv[v] = 1; ml[v] = lk; mr[v] = rl; mpart[v] = part;
               mctx[v] = rl ? 0 : ctx; mva[v] = va; mpa[v] = pa; mps[v] = ps;
            end
         end
         2: begin
            bit h[N];
            for (int i = 0; i < N; i++) h[i] = mhit(i, va, part, ctx, rl);
            for (int i = 0; i < N; i++) if (h[i]) mv[i] = 0;
         end
         3: for (int i = 0; i < N; i++) if (mpart[i] == part && mctx[i] == ctx) mv[i] = 0;
         4: for (int i = 0; i < N; i++) if (mpart[i] == part && !ml[i]) mv[i] = 0;
         5: for (int i = 0; i < N; i++) mv[i] = 0;
         default: ;
      endcase
   endtask

   task automatic step(input bit vld, input int op, input logic [63:0] va,
                       input logic [63:0] pa, input int part, input int ctx,
                       input bit rl, input int ps, input bit lk, input string tag);
      @(negedge clk);
      check_rsp();
      cmd_valid = vld;
      cmd_op    = 3'(op);
      cmd_va    = VA_W'(va);
      cmd_pa    = PA_W'(pa);
      cmd_part  = PART_W'(part);
      cmd_ctx   = CTX_W'(ctx);
      cmd_real  = rl;
      cmd_psize = 2'(ps);
      cmd_lock  = lk;
      model(vld, op, va & VA_M, pa & PA_M, part, ctx, rl, ps, lk);
      etag = tag;
   endtask

   task automatic look(input logic [63:0] va, input int part, input int ctx,
                       input bit rl, input string tag);
      step(1, 0, va, 0, part, ctx, rl, 0, 0, tag);
   endtask

   task automatic ins(input logic [63:0] va, input logic [63:0] pa, input int part,
                      input int ctx, input bit rl, input int ps, input bit lk,
                      input string tag);
      step(1, 1, va, pa, part, ctx, rl, ps, lk, tag);
   endtask

   task automatic cmd(input int op, input int part, input int ctx, input string tag);
      step(1, op, 0, 0, part, ctx, 0, 0, 0, tag);
   endtask

   localparam logic [63:0] VA_A = 64'h12_3456_6000;
   localparam logic [63:0] VA_B = 64'h00_0042_0000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (cmd_ready !== 1'b1) begin
         failures++;
         $display("FAIL R1: cmd_ready actual %0d expected 1", cmd_ready);
      end
      // R12: empty after reset
      look(64'h1000, 1, 0, 0, "R12");
      // R5 R4 R3: first inserts and matching rules
      ins(VA_A, 64'hAB_CDE0_0000, 1, 5, 0, 0, 0, "R5");
      look(64'h12_3456_7ABC, 1, 5, 0, "R4");
      look(VA_A, 2, 5, 0, "R3");
      look(VA_A, 1, 6, 0, "R3");
      look(VA_A, 1, 5, 1, "R3");
      look(VA_A + 64'h2000, 1, 5, 0, "R3");
      ins(VA_B, 64'h77_7777_7777, 1, 5, 0, 1, 0, "R4");
      look(64'h00_0042_FFFE, 1, 5, 0, "R4");
      look(64'h00_0043_0000, 1, 5, 0, "R4");
      ins(64'h05_0040_0000, 64'h3F_FFFF_FFFF, 3, 0, 0, 2, 0, "R4");
      look(64'h05_007F_1234, 3, 0, 0, "R4");
      ins(64'h20_0000_0000, 64'h10_0000_0000, 3, 11, 0, 3, 0, "R4");
      look(64'h20_0FFF_FFF0, 3, 11, 0, "R4");
      ins(64'h00_0000_8000, 64'h01_0000_0000, 1, 9, 1, 0, 0, "R3");
      look(64'h00_0000_8123, 1, 77, 1, "R3");
      look(64'h00_0000_8123, 1, 0, 0, "R3");
      ins(VA_A, 64'h99_0000_0000, 1, 5, 0, 0, 0, "R3");
      look(VA_A, 1, 5, 0, "R3");
      // R1: command without valid is ignored
      step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R1");
      look(VA_B, 1, 5, 0, "R1");
      // R7: demap page
      step(1, 2, VA_A, 0, 1, 5, 0, 0, 0, "R7");
      look(VA_A, 1, 5, 0, "R7");
      look(VA_B, 1, 5, 0, "R7");
      ins(64'h00_1111_0000, 64'h02_0000_0000, 4, 2, 0, 0, 1, "R5");
      look(64'h00_1111_0000, 4, 2, 0, "R5");
      step(1, 2, 64'h00_1111_0010, 0, 4, 2, 0, 0, 0, "R7");
      look(64'h00_1111_0000, 4, 2, 0, "R7");
      // R5: fill free slots
      for (int k = 0; k < 12; k++) begin
         ins(64'h30_0000_0000 + 64'(k) * 64'h2000, 64'h50_0000_0000 + 64'(k) * 64'h2000,
             2, 3, 0, 0, (k % 3 == 0), "R5");
         look(64'h30_0000_0000 + 64'(k) * 64'h2000 + 64'h11, 2, 3, 0, "R5");
      end
      // R6: rotating replacement
      for (int k = 0; k < 6; k++) begin
         ins(64'h31_0000_0000 + 64'(k) * 64'h2000, 64'h60_0000_0000 + 64'(k) * 64'h2000,
             2, 3, 0, 0, 0, "R6");
         look(64'h31_0000_0000 + 64'(k) * 64'h2000, 2, 3, 0, "R6");
      end
      for (int k = 0; k < 12; k++) look(64'h30_0000_0000 + 64'(k) * 64'h2000, 2, 3, 0, "R6");
      look(VA_B, 1, 5, 0, "R6");
      // R8: context sweep
      cmd(3, 1, 7, "R8");
      look(VA_B, 1, 5, 0, "R8");
      cmd(3, 2, 3, "R8");
      for (int k = 0; k < 12; k += 4) look(64'h30_0000_0000 + 64'(k) * 64'h2000, 2, 3, 0, "R8");
      look(64'h31_0000_0000, 2, 3, 0, "R8");
      // R9: partition sweep
      ins(64'h40_0000_0000, 64'h0A_0000_0000, 6, 1, 0, 0, 1, "R9");
      ins(64'h40_0000_2000, 64'h0B_0000_0000, 6, 1, 0, 0, 0, "R9");
      cmd(4, 6, 0, "R9");
      look(64'h40_0000_0000, 6, 1, 0, "R9");
      look(64'h40_0000_2000, 6, 1, 0, "R9");
      look(VA_B, 1, 5, 0, "R9");
      // R10: invalidate all
      cmd(5, 0, 0, "R10");
      look(VA_B, 1, 5, 0, "R10");
      look(64'h40_0000_0000, 6, 1, 0, "R10");
      // R6: all locked, insert dropped
      for (int k = 0; k < N; k++)
         ins(64'h50_0000_0000 + 64'(k) * 64'h2000, 64'h70_0000_0000 + 64'(k) * 64'h2000,
             7, 4, 0, 0, 1, "R6");
      ins(64'h51_0000_0000, 64'h0C_0000_0000, 7, 4, 0, 0, 0, "R6");
      look(64'h51_0000_0000, 7, 4, 0, "R6");
      look(64'h50_0000_0000, 7, 4, 0, "R6");
      cmd(4, 7, 0, "R9");
      look(64'h50_0000_2000, 7, 4, 0, "R9");
      // R11: unassigned opcodes
      step(1, 6, 64'h50_0000_4000, 0, 7, 4, 0, 0, 0, "R11");
      step(1, 7, 64'h50_0000_4000, 0, 7, 4, 0, 0, 0, "R11");
      look(64'h50_0000_4000, 7, 4, 0, "R11");
      cmd(5, 0, 0, "R10");
      look(64'h50_0000_4000, 7, 4, 0, "R10");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 20000);
      failures++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule